// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block holds the operating mode of a small processor subsystem and turns it into the enables and selects that drive the clock tree. It has five modes. In active and subactive the CPU runs, from the main clock or from the slow subclock. In sleep and subsleep the CPU clock is stopped but the peripherals keep running. In standby the main oscillator is switched off. A sleep request from the CPU moves the block from a running mode to the matching stopped mode. If a separate qualifier is set with the request, the block goes to standby instead.

The block leaves any stopped mode when an interrupt request is pending on a source whose enable bit is set and the global interrupt mask is clear. On that edge it raises a one-cycle wake pulse that starts interrupt handling. It returns to active or to subactive according to a low-speed select bit. That bit, and the peripheral clock divider select, are sampled while the CPU runs and held frozen while it is stopped. Software can therefore rewrite its settings during sleep without the change taking effect before the wake.

The block never drives a reset toward the CPU, so processor state survives every sleep. Only the asynchronous, active-low reset pin returns the block to active mode, and it does so from any mode.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While `rst_n` is low, and at once when it falls, even without a clock edge and from any mode including sleep, `mode` is 3'b000 (active), `wake_pulse` is 0, `pdiv_out` is 0, `cpu_clk_en` is 1, `subclk_sel` is 0 and `sysosc_en` is 1.
- R2: `mode` uses the codes 000 active, 001 sleep, 010 subactive, 011 subsleep and 100 standby, and never takes any other value. With `sleep_req` high and `standby_qual` low, active becomes sleep and subactive becomes subsleep at the next edge.
- R3: With `sleep_req` and `standby_qual` both high, active or subactive becomes standby (100) at the next edge.
- R4: `cpu_clk_en` is 1 only in active and subactive. `subclk_sel` is 1 only in subactive and subsleep. `sysosc_en` is 0 only in standby.
- R5: In sleep, subsleep or standby, when `int_mask` is 0 and some bit i has both `irq_req[i]` and `irq_en[i]` high at a clock edge, the mode changes to a running mode on that edge. `wake_pulse` is high for exactly the one following cycle.
- R6: In a stopped mode, a request whose enable bit is low, or any request while `int_mask` is 1, leaves the mode unchanged and `wake_pulse` low.
- R7: A wake leads to active (000) if the held low-speed select is 0 and to subactive (010) if it is 1.
- R8: In running modes, `pdiv_out` and the held low-speed select load `pdiv_sel` and `lowspeed_sel` at each edge. In stopped modes both hold the values loaded on the entry edge, so changes to `pdiv_sel` or `lowspeed_sel` during a stop affect neither `pdiv_out` nor the wake target.
- R9: `sleep_req` is ignored in stopped modes, and interrupt requests are ignored in running modes (no `wake_pulse`, no mode change).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | CPU request to stop |
| standby_qual | input | 1 | Turns a sleep request into a standby request |
| irq_req | input | N_IRQ | Level-sensitive interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| int_mask | input | 1 | Global interrupt mask (1 blocks wake) |
| lowspeed_sel | input | 1 | Wake target select (1 = subactive) |
| pdiv_sel | input | DIV_W | Peripheral clock divider select |
| mode | output | 3 | Current operating mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| pdiv_out | output | DIV_W | Held peripheral divider select |
| subclk_sel | output | 1 | System runs from the subclock |
| sysosc_en | output | 1 | Main oscillator enable |
| wake_pulse | output | 1 | One-cycle start of interrupt handling |

## Verification
The properties assume that `irq_req`, `irq_en`, `int_mask` and `sleep_req` are synchronous to `clk` and settle before each edge. The wake and hold checks compare the values sampled at one edge with the mode at the next. The bench changes every input only on the falling edge and releases reset away from the rising edge. Each stimulus vector therefore meets exactly one rising edge, and no property sees an input that changes inside a cycle.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [2:0] {
    MD_ACTIVE   = 3'b000,
    MD_SLEEP    = 3'b001,
    MD_SUBACT   = 3'b010,
    MD_SUBSLEEP = 3'b011,
    MD_STANDBY  = 3'b100
  } pm_mode_e;

  function automatic logic pm_is_running(input pm_mode_e m);
    return (m == MD_ACTIVE) || (m == MD_SUBACT);
  endfunction
endpackage

// File: rtl/pwrmode_wake_qual.sv
module pwrmode_wake_qual #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             int_mask,
  output logic             wake_ok
);
  logic [N_IRQ-1:0] live;

  genvar gi;
  generate
    for (gi = 0; gi < N_IRQ; gi++) begin : g_src
      assign live[gi] = irq_req[gi] & irq_en[gi];
    end
  endgenerate

  assign wake_ok = ~int_mask & (|live);
endmodule

// File: rtl/pwrmode_cfg_hold.sv
module pwrmode_cfg_hold #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] pdiv_sel,
  input  logic             lowspeed_sel,
  output logic [DIV_W-1:0] pdiv_q,
  output logic             lowspeed_q
);
  // loaded every running cycle, frozen through any stop (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv_q     <= '0;
      lowspeed_q <= 1'b0;
    end else if (load) begin
      pdiv_q     <= pdiv_sel;
      lowspeed_q <= lowspeed_sel;
    end
  end
endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
  import pwrmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sleep_req,
  input  logic     standby_qual,
  input  logic     wake_ok,
  input  logic     lowspeed_q,
  output pm_mode_e state,
  output logic     wake_pulse
);
  pm_mode_e nxt;
  logic     leaving;

  always_comb begin
    nxt     = state;
    leaving = 1'b0;
    unique case (state)
      MD_ACTIVE: if (sleep_req) nxt = standby_qual ? MD_STANDBY : MD_SLEEP;
      MD_SUBACT: if (sleep_req) nxt = standby_qual ? MD_STANDBY : MD_SUBSLEEP;
      MD_SLEEP, MD_SUBSLEEP, MD_STANDBY: begin
        if (wake_ok) begin
          leaving = 1'b1;
          nxt     = lowspeed_q ? MD_SUBACT : MD_ACTIVE;
        end
      end
      default: nxt = MD_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= MD_ACTIVE;
      wake_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      wake_pulse <= leaving;
    end
  end
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             standby_qual,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             int_mask,
  input  logic             lowspeed_sel,
  input  logic [DIV_W-1:0] pdiv_sel,
  output logic [2:0]       mode,
  output logic             cpu_clk_en,
  output logic [DIV_W-1:0] pdiv_out,
  output logic             subclk_sel,
  output logic             sysosc_en,
  output logic             wake_pulse
);
  pm_mode_e st;
  logic     wake_ok;
  logic     ls_q;

  pwrmode_wake_qual #(.N_IRQ(N_IRQ)) u_wq (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .int_mask(int_mask),
    .wake_ok (wake_ok)
  );

  pwrmode_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (pm_is_running(st)),
    .pdiv_sel    (pdiv_sel),
    .lowspeed_sel(lowspeed_sel),
    .pdiv_q      (pdiv_out),
    .lowspeed_q  (ls_q)
  );

  pwrmode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .standby_qual(standby_qual),
    .wake_ok     (wake_ok),
    .lowspeed_q  (ls_q),
    .state       (st),
    .wake_pulse  (wake_pulse)
  );

  assign mode       = st;
  assign cpu_clk_en = pm_is_running(st);
  assign subclk_sel = (st == MD_SUBACT) || (st == MD_SUBSLEEP);
  assign sysosc_en  = (st != MD_STANDBY);
endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk #(
  parameter int N_IRQ = 4,
  parameter int DIV_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             int_mask,
  input logic [2:0]       mode,
  input logic             cpu_clk_en,
  input logic [DIV_W-1:0] pdiv_out,
  input logic             sysosc_en,
  input logic             wake_pulse
);
  logic stopped;
  assign stopped = (mode == 3'b001) || (mode == 3'b011) || (mode == 3'b100);

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

  assert_standby_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100) |-> (!sysosc_en && !cpu_clk_en));

  assert_wake_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_wake_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (cpu_clk_en && $past(stopped)));

  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && int_mask) |=> ($stable(mode) && !wake_pulse));

  assert_disabled_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && ((irq_req & irq_en) == '0)) |=> ($stable(mode) && !wake_pulse));

  assert_div_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> $stable(pdiv_out));

  assert_irq_ignored_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |=> !wake_pulse);

  assert_sleepreq_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && sleep_req && int_mask) |=> stopped);
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk #(.N_IRQ(N_IRQ), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_req (sleep_req),
  .irq_req   (irq_req),
  .irq_en    (irq_en),
  .int_mask  (int_mask),
  .mode      (mode),
  .cpu_clk_en(cpu_clk_en),
  .pdiv_out  (pdiv_out),
  .sysosc_en (sysosc_en),
  .wake_pulse(wake_pulse)
);

// File: tb/pwrmode_ctrl_tb.sv
`timescale 1ns/1ps
module pwrmode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0, standby_qual = 1'b0, int_mask = 1'b0, lowspeed_sel = 1'b0;
  logic [3:0] irq_req = '0, irq_en = '0;
  logic [2:0] pdiv_sel = '0;
  logic [2:0] mode;
  logic       cpu_clk_en, subclk_sel, sysosc_en, wake_pulse;
  logic [2:0] pdiv_out;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwrmode_ctrl #(.N_IRQ(4), .DIV_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .standby_qual(standby_qual),
    .irq_req(irq_req), .irq_en(irq_en), .int_mask(int_mask),
    .lowspeed_sel(lowspeed_sel), .pdiv_sel(pdiv_sel), .mode(mode),
    .cpu_clk_en(cpu_clk_en), .pdiv_out(pdiv_out), .subclk_sel(subclk_sel),
    .sysosc_en(sysosc_en), .wake_pulse(wake_pulse)
  );

  // {sleep_req, standby_qual, irq_req, irq_en, int_mask, lowspeed_sel, pdiv_sel,
  //  expected mode, expected wake_pulse, expected pdiv_out}
  localparam logic [21:0] VECS [0:12] = '{
    22'b0_0_0000_0000_0_0_011_000_0_011,  // R8 divider tracks in active
    22'b1_0_0000_0000_0_1_101_001_0_101,  // R2 active -> sleep
    22'b1_0_0001_0000_0_0_010_001_0_101,  // R6 disabled source, R9 sleep_req ignored
    22'b0_0_0001_0001_1_0_010_001_0_101,  // R6 global mask
    22'b0_0_0010_0001_0_0_010_001_0_101,  // R6 enable on other source
    22'b0_0_0010_0010_0_0_010_010_1_101,  // R5 R7 wake to subactive
    22'b0_0_0010_0010_0_0_010_010_0_010,  // R5 single pulse, R9 irq ignored
    22'b1_0_0000_0000_0_0_110_011_0_110,  // R2 subactive -> subsleep
    22'b0_0_1000_1000_0_1_000_000_1_110,  // R7 R8 held ls=0 wins
    22'b1_1_0000_0000_0_0_001_100_0_001,  // R3 active -> standby
    22'b0_0_0100_0100_1_0_111_100_0_001,  // R6 mask in standby
    22'b0_0_0100_0100_0_0_111_000_1_001,  // R5 wake from standby
    22'b0_0_0000_0000_0_0_100_000_0_100   // R8 tracking resumes
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_mode_outs(input string req, input logic [2:0] m);
    check({req, " cpu_clk_en"}, {7'd0, cpu_clk_en}, {7'd0, (m == 3'b000) || (m == 3'b010)});
    check({req, " subclk_sel"}, {7'd0, subclk_sel}, {7'd0, (m == 3'b010) || (m == 3'b011)});
    check({req, " sysosc_en"}, {7'd0, sysosc_en}, {7'd0, m != 3'b100});
  endtask

  task automatic step(input logic sr, input logic sq, input logic [3:0] rq, input logic [3:0] en,
                      input logic mk, input logic ls, input logic [2:0] dv);
    sleep_req = sr; standby_qual = sq; irq_req = rq; irq_en = en;
    int_mask = mk; lowspeed_sel = ls; pdiv_sel = dv;
    @(negedge clk);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 mode in reset", {5'd0, mode}, 8'h00);
    check("R1 wake in reset", {7'd0, wake_pulse}, 8'h00);
    check("R1 pdiv in reset", {5'd0, pdiv_out}, 8'h00);
    check_mode_outs("R1 R4 reset", 3'b000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      logic [21:0] v;
      v = VECS[i];
      step(v[21], v[20], v[19:16], v[15:12], v[11], v[10], v[9:7]);
      check($sformatf("R2 R5 R6 R7 R9 mode vec%0d", i), {5'd0, mode}, {5'd0, v[6:4]});
      check($sformatf("R5 wake vec%0d", i), {7'd0, wake_pulse}, {7'd0, v[3]});
      check($sformatf("R8 pdiv vec%0d", i), {5'd0, pdiv_out}, {5'd0, v[2:0]});
      check_mode_outs($sformatf("R4 vec%0d", i), v[6:4]);
    end

    // R3 from subactive, then R7 wake target captured as 1
    step(1, 0, 4'b0000, 4'b0000, 0, 1, 3'd2);
    check("R2 sleep", {5'd0, mode}, 8'h01);
    step(0, 0, 4'b0001, 4'b0001, 0, 0, 3'd2);
    check("R7 to subactive", {5'd0, mode}, 8'h02);
    step(1, 1, 4'b0000, 4'b0000, 0, 1, 3'd3);
    check("R3 subactive -> standby", {5'd0, mode}, 8'h04);
    check_mode_outs("R4 standby", 3'b100);
    step(0, 0, 4'b0001, 4'b0001, 0, 0, 3'd5);
    check("R7 standby -> subactive", {5'd0, mode}, 8'h02);
    check("R8 pdiv held", {5'd0, pdiv_out}, 8'h03);
    step(1, 0, 4'b0000, 4'b0000, 0, 0, 3'd6);
    check("R2 subactive -> subsleep", {5'd0, mode}, 8'h03);
    check_mode_outs("R4 subsleep", 3'b011);

    // R1 asynchronous reset out of a stopped mode, away from the edge
    #2 rst_n = 1'b0;
    #1;
    check("R1 async mode", {5'd0, mode}, 8'h00);
    check("R1 async pdiv", {5'd0, pdiv_out}, 8'h00);
    check("R1 async wake", {7'd0, wake_pulse}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 4'b0000, 4'b0000, 0, 0, 3'd0);
    check("R1 active after reset", {5'd0, mode}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule